// File: doc/BRIEF.md
# Bitfield Insert and Extract Unit

This block is a purely combinational 64-bit bitfield engine for an integer datapath. It takes the current destination value, a source operand, a field position and a field length, plus a two-bit operation code. It produces the new destination value in the same cycle. Three operations are supported:

- **Merge insert** drops the low bits of the source into the destination and keeps every other destination bit.
- **Clear insert** drops the same field into an otherwise zero word.
- **Unsigned extract** lifts a field out of the source and right-justifies it.

A single mask generator and a single two-lane shifter serve all three operations. An operation-select mux picks the final word. A separate legality checker flags field descriptions that do not fit in the word, a zero length, or the reserved operation code. When the flag is raised, the destination passes through untouched, so the caller can retire the operation as a no-op. There is no state and no clock. The operation select takes the place of a state: each code names one datapath configuration, and there are no transitions.

Top module: `bfu_unit`

## Requirements
- R1: With op code 2'b00 (merge insert), bits [len-1:0] of the source appear at result bits [pos+len-1:pos], and every other result bit equals the destination bit at the same position.
- R2: With op code 2'b01 (clear insert), the field is placed exactly as in R1, and every result bit outside [pos+len-1:pos] is zero, whatever the destination holds.
- R3: Clear insert is unsigned: when the field's top bit is 1, the result bits above the field stay zero.
- R4: With op code 2'b10 (unsigned extract), source bits [pos+len-1:pos] appear at result bits [len-1:0], and all result bits from len upward are zero.
- R5: A length of 64 with position 0 yields the full source word for all three operations, with the flag low.
- R6: When pos + len > 64, illegal_o is 1 and result_o equals dst_i.
- R7: A length of 0, or a length above 64, sets illegal_o to 1 and makes result_o equal dst_i.
- R8: Op code 2'b11 is reserved: it sets illegal_o to 1 and makes result_o equal dst_i.
- R9: For any legal field (1 <= len, pos + len <= 64, op code not 2'b11), illegal_o is 0. This includes a field that ends exactly at bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 64 | Current destination word |
| src_i | input | 64 | Source operand |
| pos_i | input | 6 | Field position (lowest bit index of the field in the word) |
| len_i | input | 7 | Field length in bits (legal range 1 to 64) |
| op_i | input | 2 | 00 merge insert, 01 clear insert, 10 unsigned extract, 11 reserved |
| result_o | output | 64 | New destination value |
| illegal_o | output | 1 | High when the field or operation is not legal |

## Verification
Legality checking and field placement are evaluated together on every input vector. The interesting corner is a field that ends exactly at bit 63 compared with one that overhangs it by one bit. The bench drives matched pairs of such vectors: the first must produce a correctly placed field with the flag low, and the second must pass the destination through with the flag high. Random vectors, with lengths chosen to land on both sides of that edge, are judged against a bit-by-bit reference model in the bench.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

    localparam int unsigned DATA_W = 64;
    localparam int unsigned POS_W  = $clog2(DATA_W);
    localparam int unsigned LEN_W  = $clog2(DATA_W) + 1;

    typedef enum logic [1:0] {
        BF_MERGE   = 2'b00,
        BF_CLEAR   = 2'b01,
        BF_EXTRACT = 2'b10,
        BF_RSVD    = 2'b11
    } bf_op_e;

endpackage

// File: rtl/bfu_field_check.sv
module bfu_field_check
    import bfu_pkg::*;
#(
    parameter int unsigned W     = DATA_W,
    parameter int unsigned PW    = $clog2(W),
    parameter int unsigned LW    = $clog2(W) + 1
) (
    input  logic [PW-1:0] pos_i,
    input  logic [LW-1:0] len_i,
    input  bf_op_e        op_i,
    output logic          bad_o
);
    localparam int unsigned SUM_W = LW + 1;

    logic [SUM_W-1:0] span_end;
    logic             len_zero;
    logic             len_big;
    logic             overhang;
    logic             op_bad;

    always_comb begin
        span_end = SUM_W'(pos_i) + SUM_W'(len_i);
        len_zero = (len_i == '0);
        len_big  = (SUM_W'(len_i) > SUM_W'(W));
        overhang = (span_end > SUM_W'(W));
        op_bad   = (op_i == BF_RSVD);
        bad_o    = len_zero | len_big | overhang | op_bad;
    end

endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
    parameter int unsigned W  = 64,
    parameter int unsigned LW = $clog2(W) + 1
) (
    input  logic [LW-1:0] len_i,
    output logic [W-1:0]  mask_o
);
    // one comparator per bit: no carry out of the top bit at full length
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign mask_o[b] = (LW'(b) < len_i);
    end

endmodule

// File: rtl/bfu_shifter.sv
module bfu_shifter #(
    parameter int unsigned W     = 64,
    parameter int unsigned PW    = $clog2(W),
    parameter int unsigned LANES = 2
) (
    input  logic                     left_i,
    input  logic [PW-1:0]            amt_i,
    input  logic [LANES-1:0][W-1:0]  lane_i,
    output logic [LANES-1:0][W-1:0]  lane_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            if (left_i) lane_o[l] = lane_i[l] << amt_i;
            else        lane_o[l] = lane_i[l] >> amt_i;
        end
    end

endmodule

// File: rtl/bfu_unit.sv
module bfu_unit
    import bfu_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned PW = $clog2(W),
    parameter int unsigned LW = $clog2(W) + 1
) (
    input  logic [W-1:0]  dst_i,
    input  logic [W-1:0]  src_i,
    input  logic [PW-1:0] pos_i,
    input  logic [LW-1:0] len_i,
    input  logic [1:0]    op_i,
    output logic [W-1:0]  result_o,
    output logic          illegal_o
);
    localparam int unsigned LANE_DATA = 0;
    localparam int unsigned LANE_MASK = 1;

    bf_op_e              op_sel;
    logic [W-1:0]        fmask;
    logic                shl;
    logic [1:0][W-1:0]   sh_in;
    logic [1:0][W-1:0]   sh_out;
    logic                bad;

    assign op_sel = bf_op_e'(op_i);

    bfu_field_check #(.W(W), .PW(PW), .LW(LW)) u_check (
        .pos_i (pos_i),
        .len_i (len_i),
        .op_i  (op_sel),
        .bad_o (bad)
    );

    bfu_mask_gen #(.W(W), .LW(LW)) u_mask (
        .len_i  (len_i),
        .mask_o (fmask)
    );

    always_comb begin
        shl                = (op_sel != BF_EXTRACT);
        sh_in[LANE_DATA]   = shl ? (src_i & fmask) : src_i;
        sh_in[LANE_MASK]   = fmask;
    end

    bfu_shifter #(.W(W), .PW(PW), .LANES(2)) u_shift (
        .left_i (shl),
        .amt_i  (pos_i),
        .lane_i (sh_in),
        .lane_o (sh_out)
    );

    always_comb begin
        result_o  = dst_i;
        illegal_o = bad;
        if (!bad) begin
            unique case (op_sel)
                BF_MERGE:   result_o = (dst_i & ~sh_out[LANE_MASK]) | sh_out[LANE_DATA];
                BF_CLEAR:   result_o = sh_out[LANE_DATA];
                BF_EXTRACT: result_o = sh_out[LANE_DATA] & fmask;
                default:    result_o = dst_i;
            endcase
        end
    end

    always_comb begin
        // R6
        bad_keeps_dst_chk: assert (!illegal_o || result_o == dst_i);
        // R1
        merge_outside_chk: assert (illegal_o || op_sel != BF_MERGE ||
            ((result_o ^ dst_i) & ~sh_out[LANE_MASK]) == '0);
        // R2
        clear_outside_chk: assert (illegal_o || op_sel != BF_CLEAR ||
            (result_o & ~sh_out[LANE_MASK]) == '0);
        // R4
        extract_upper_chk: assert (illegal_o || op_sel != BF_EXTRACT ||
            (result_o & ~fmask) == '0);
        // R5
        full_copy_chk: assert (!(len_i == LW'(W) && pos_i == '0 && op_sel != BF_RSVD) ||
            (!illegal_o && result_o == src_i));
    end

endmodule

// File: tb/bfu_unit_bench.sv
module bfu_unit_bench;
    localparam int W = 64;

    logic         clk;
    logic [W-1:0] dst, src;
    logic [5:0]   pos;
    logic [6:0]   len;
    logic [1:0]   op;
    logic [W-1:0] res;
    logic         ill;

    int vectors = 0;
    int miss    = 0;
    bit done    = 0;

    bfu_unit u_bfu_unit (
        .dst_i(dst), .src_i(src), .pos_i(pos), .len_i(len), .op_i(op),
        .result_o(res), .illegal_o(ill)
    );

    initial clk = 0;
    always #10 clk = ~clk;

    function automatic void model(input logic [1:0] o, input logic [W-1:0] d,
                                  input logic [W-1:0] s, input int p, input int n,
                                  output logic [W-1:0] r, output logic f);
        f = (n == 0) || (n > 64) || (p + n > 64) || (o == 2'b11);
        r = d;
        if (!f) begin
            for (int i = 0; i < W; i++) begin
                case (o)
                    2'b00: r[i] = (i >= p && i < p + n) ? s[i-p] : d[i];
                    2'b01: r[i] = (i >= p && i < p + n) ? s[i-p] : 1'b0;
                    default: r[i] = (i < n) ? s[i+p] : 1'b0;
                endcase
            end
        end
    endfunction

    task automatic apply(input string req, input logic [1:0] o, input logic [W-1:0] d,
                         input logic [W-1:0] s, input int p, input int n);
        logic [W-1:0] er;
        logic         ef;
        @(posedge clk);
        op = o; dst = d; src = s; pos = 6'(p); len = 7'(n);
        model(o, d, s, p, n, er, ef);
        @(negedge clk);
        vectors++;
        if (res !== er || ill !== ef) begin
            miss++;
            $display("FAIL %s: op=%0d pos=%0d len=%0d got res=%h ill=%b exp res=%h ill=%b",
                     req, o, p, n, res, ill, er, ef);
        end
    endtask

    task automatic t_idle;
        // R7: all-zero inputs, zero length
        apply("R7", 2'b00, 64'h0, 64'h0, 0, 0);
    endtask

    task automatic t_merge;
        apply("R1", 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8, 8);
        apply("R1", 2'b00, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFF5, 20, 4);
        apply("R1", 2'b00, 64'hAAAA_AAAA_AAAA_AAAA, 64'h1, 0, 1);
    endtask

    task automatic t_clear;
        apply("R2", 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_00A5, 12, 8);
        // R3: field top bit set, nothing above it
        apply("R3", 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0080, 4, 8);
        apply("R3", 2'b01, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 16, 16);
    endtask

    task automatic t_extract;
        apply("R4", 2'b10, 64'h5555_5555_5555_5555, 64'hDEAD_BEEF_CAFE_F00D, 16, 16);
        apply("R4", 2'b10, 64'h0, 64'h8000_0000_0000_0000, 63, 1);
        apply("R4", 2'b10, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 40, 24);
    endtask

    task automatic t_full;
        for (int o = 0; o < 3; o++)
            apply("R5", 2'(o), 64'h1111_2222_3333_4444, 64'h9876_5432_10FE_DCBA, 0, 64);
    endtask

    task automatic t_edges;
        // R9 fits exactly at bit 63; R6 one bit over
        apply("R9", 2'b00, 64'h0, 64'hF, 60, 4);
        apply("R6", 2'b00, 64'h1234, 64'hF, 61, 4);
        apply("R9", 2'b01, 64'h0, 64'h1, 63, 1);
        apply("R6", 2'b10, 64'h77, 64'hFFFF, 63, 2);
        apply("R7", 2'b01, 64'hABCD, 64'hFFFF, 0, 0);
        apply("R7", 2'b00, 64'hABCD, 64'hFFFF, 0, 65);
        apply("R8", 2'b11, 64'hCAFE, 64'hFFFF, 4, 4);
    endtask

    task automatic t_random;
        for (int k = 0; k < 600; k++) begin
            int n = 1 + ($urandom % 64);
            int p = $urandom % 64;
            apply("R9", 2'($urandom % 4), {$urandom, $urandom}, {$urandom, $urandom}, p, n);
        end
    endtask

    initial begin
        op = 2'b00; dst = '0; src = '0; pos = '0; len = '0;
        repeat (2) @(posedge clk);
        t_idle;
        t_merge;
        t_clear;
        t_extract;
        t_full;
        t_edges;
        t_random;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

endmodule